// File: doc/BRIEF.md
# Horizontal Cell Down-Counter

This block keeps track of how many character half-cycles remain on the current raster line. At the start of each line it is loaded with twice the programmed column count, because every character takes two fetch steps. It then counts down by one on each step strobe. When the count reaches zero, the done flag tells the fetch logic to stop fetching and to start the right border.

The counter is built from 4-bit nibbles. The low nibble decrements on every accepted step. Each higher nibble decrements only when a registered borrow bit says that every bit below it is zero. Those borrow registers are updated only on an accepted step or on a load. A load always rewrites them from the freshly loaded value, so borrow state from the previous line can never reach the new one. Once the count is at zero, steps are ignored and the count does not wrap. The load and step strobes are not meant to occur together; if they do, the load wins.

Top module: `hcell_down_counter`

## Requirements
- R1: After reset, `cell_count` is 0 and `cells_done` is 1.
- R2: A cycle with `line_load` high sets `cell_count` to twice `col_count` at the next clock edge, i.e. `{col_count, 1'b0}`.
- R3: A cycle with `cell_step` high, `line_load` low and `cell_count` non-zero lowers `cell_count` by exactly one at the next edge.
- R4: The decrement is exact across nibble boundaries. A count of 0x10 steps to 0x0F, and 0x80 steps to 0x7F. This also holds for the first step after a load whose low nibble is zero.
- R5: A load discards any borrow state left from before it. After a load of 0x12 taken while the count was 0x10, the next step gives 0x11. After a load of 0x10 taken while the count was 0x11, the next step gives 0x0F.
- R6: `cells_done` is 1 exactly when `cell_count` is 0.
- R7: A step while `cell_count` is 0 is ignored: the count stays 0 and `cells_done` stays 1.
- R8: A load with `col_count` equal to 0 gives `cells_done` = 1 in the cycle after the load.
- R9: When `line_load` and `cell_step` are both high, the load takes effect and the step is ignored.
- R10: With neither strobe high, `cell_count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock (fetch-phase clock) |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_load | input | 1 | Start-of-line strobe; loads twice `col_count` |
| col_count | input | COL_W (7) | Programmed number of character columns |
| cell_step | input | 1 | One fetch half-cycle step |
| cell_count | output | COL_W+1 (8) | Remaining half-cycles on the line |
| cells_done | output | 1 | High when no half-cycles remain |

## Verification
The embedded assertions watch every cycle for the following:
- each load result, including the simultaneous load-and-step case;
- each single-step decrement in every nibble;
- the hold at zero and the hold when idle;
- the borrow registers matching the lower count bits after every load and every accepted step.

Only the bench's scenarios can show the end-to-end sequences. These are the full countdown from the largest column count, with every nibble crossing on the way, and the two stale-borrow cases in which a load lands on top of a pending or absent borrow. They also show that the done flag appears exactly on the cycle the count empties.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

  // Operation applied to one nibble of the down-counter in a cycle
  typedef enum logic [1:0] {
    NIB_HOLD = 2'd0,
    NIB_LOAD = 2'd1,
    NIB_DEC  = 2'd2
  } nib_op_e;

endpackage

// File: rtl/hcc_nibble.sv
module hcc_nibble
  import hcc_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  nib_op_e       op,
  input  logic [NW-1:0] ld_val,
  output logic [NW-1:0] q
);

  // Next value of one nibble for a given operation
  function automatic logic [NW-1:0] nib_next(nib_op_e o, logic [NW-1:0] cur,
                                             logic [NW-1:0] lv);
    logic [NW-1:0] r;
    case (o)
      NIB_LOAD: r = lv;
      NIB_DEC:  r = cur - NW'(1);
      default:  r = cur;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nib_next(op, q, ld_val);
  end

  // R4
  nib_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == NIB_DEC) |=> (q == ($past(q) - NW'(1))));

  // R10
  nib_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == NIB_HOLD) |=> $stable(q));

endmodule

// File: rtl/hcc_borrow_stage.sv
module hcc_borrow_stage #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [LW-1:0] ld_low,
  input  logic          step_acc,
  input  logic [LW-1:0] cur_low,
  output logic          brw_q
);

  // After an accepted step the lower field is zero iff it was one before.
  function automatic logic low_zero_after_step(logic [LW-1:0] v);
    return (v == LW'(1));
  endfunction

  // Borrow register updated only by load or step; a load always overwrites it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        brw_q <= 1'b1;
    else if (ld)       brw_q <= (ld_low == '0);
    else if (step_acc) brw_q <= low_zero_after_step(cur_low);
  end

  // R5
  stale_brw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (brw_q == (cur_low == '0)));

  // R4
  brw_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_acc && !ld) |=> (brw_q == (cur_low == '0)));

endmodule

// File: rtl/hcell_down_counter.sv
module hcell_down_counter
  import hcc_pkg::*;
#(
  parameter  int COL_W = 7,
  parameter  int NIB_W = 4,
  localparam int CNT_W = COL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_load,
  input  logic [COL_W-1:0] col_count,
  input  logic             cell_step,
  output logic [CNT_W-1:0] cell_count,
  output logic             cells_done
);

  localparam int NIBS = CNT_W / NIB_W;

  // Each character takes two steps, so the line starts at twice the columns
  function automatic logic [CNT_W-1:0] line_start(logic [COL_W-1:0] cols);
    return {cols, 1'b0};
  endfunction

  logic [CNT_W-1:0] load_val;
  logic             at_zero;
  logic             step_acc;
  logic [NIBS-1:0]  nib_brw;

  assign load_val   = line_start(col_count);
  assign at_zero    = (cell_count == '0);
  assign step_acc   = cell_step && !line_load && !at_zero;
  assign cells_done = at_zero;

  for (genvar i = 0; i < NIBS; i++) begin : g_nib
    nib_op_e op;

    if (i == 0) begin : g_first
      assign nib_brw[i] = 1'b1;
    end else begin : g_brw
      hcc_borrow_stage #(.LW(i * NIB_W)) u_brw (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (line_load),
        .ld_low   (load_val[i*NIB_W-1:0]),
        .step_acc (step_acc),
        .cur_low  (cell_count[i*NIB_W-1:0]),
        .brw_q    (nib_brw[i])
      );
    end

    always_comb begin
      if (line_load)                 op = NIB_LOAD;
      else if (step_acc && nib_brw[i]) op = NIB_DEC;
      else                           op = NIB_HOLD;
    end

    hcc_nibble #(.NW(NIB_W)) u_nib (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .ld_val (load_val[i*NIB_W +: NIB_W]),
      .q      (cell_count[i*NIB_W +: NIB_W])
    );
  end

  // R2 R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_load |=> (cell_count == {$past(col_count), 1'b0}));

  // R3
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_step && !line_load && (cell_count != '0))
      |=> (cell_count == ($past(cell_count) - CNT_W'(1))));

  // R7
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_step && !line_load && cells_done) |=> (cells_done && (cell_count == '0)));

  // R8
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_load && (col_count == '0)) |=> cells_done);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_load && !cell_step) |=> $stable(cell_count));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cells_done) |-> (cell_count == '0));

endmodule

// File: tb/hcell_down_counter_tb.sv
`timescale 1ns/1ps
module hcell_down_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_load = 1'b0;
  logic [6:0] col_count = '0;
  logic       cell_step = 1'b0;
  logic [7:0] cell_count;
  logic       cells_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int exp_cnt = 0;

  always #2 clk = ~clk;

  hcell_down_counter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_load  (line_load),
    .col_count  (col_count),
    .cell_step  (cell_step),
    .cell_count (cell_count),
    .cells_done (cells_done)
  );

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(req, int'(cell_count), exp_cnt);
    chk({req, "/R6"}, int'(cells_done), (exp_cnt == 0) ? 1 : 0);
  endtask

  // One clock with the given strobes, driven and sampled on falling edges
  task automatic cyc(bit ld, int cols, bit st);
    line_load = ld;
    col_count = 7'(cols);
    cell_step = st;
    @(negedge clk);
    line_load = 1'b0;
    cell_step = 1'b0;
    if (ld)                    exp_cnt = 2 * cols;
    else if (st && exp_cnt != 0) exp_cnt = exp_cnt - 1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset();
    chk_state("R1");
  endtask

  task automatic t_count_to_zero();
    cyc(1, 5, 0);
    chk_state("R2");
    for (int k = 0; k < 10; k++) begin
      cyc(0, 0, 1);
      chk_state("R3");
    end
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 1);
      chk_state("R7");
    end
  endtask

  task automatic t_nibble_cross();
    cyc(1, 8, 0);
    chk_state("R2");
    cyc(0, 0, 1);
    chk_state("R4");
    cyc(1, 64, 0);
    cyc(0, 0, 1);
    chk_state("R4");
    cyc(1, 127, 0);
    chk_state("R2");
    for (int k = 0; k < 254; k++) begin
      cyc(0, 0, 1);
      chk_state("R4");
    end
    cyc(0, 0, 1);
    chk_state("R7");
  endtask

  task automatic t_stale_borrow();
    cyc(1, 9, 0);
    cyc(0, 0, 1);
    cyc(0, 0, 1);
    chk_state("R5");
    cyc(1, 9, 0);
    cyc(0, 0, 1);
    chk_state("R5");
    chk("R5", int'(cell_count), 8'h11);
    cyc(1, 8, 0);
    cyc(0, 0, 1);
    chk_state("R5");
    chk("R5", int'(cell_count), 8'h0F);
  endtask

  task automatic t_zero_load();
    cyc(1, 20, 0);
    cyc(1, 0, 0);
    chk_state("R8");
    chk("R8", int'(cells_done), 1);
  endtask

  task automatic t_priority();
    cyc(1, 30, 0);
    cyc(1, 3, 1);
    chk_state("R9");
    chk("R9", int'(cell_count), 6);
  endtask

  task automatic t_idle();
    cyc(1, 45, 0);
    cyc(0, 0, 1);
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0);
      chk_state("R10");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_to_zero();
    t_nibble_cross();
    t_stale_borrow();
    t_zero_load();
    t_priority();
    t_idle();
    summary();
  end

endmodule